// File: doc/BRIEF.md
# Configurable Event Detection Router

The block collects six event lines, already synchronised to the system clock, and turns them into one registered interrupt/wakeup request. Bit positions are fixed: bits 0 to 3 are four external wakeup lines, bit 4 is the alarm-timer event and bit 5 is the real-time-clock event. Each line has two configuration bits. A mode bit selects level or edge detection, and a polarity bit selects low/falling or high/rising. A detected event latches into a sticky status bit.

Each status bit is ANDed with its own enable bit. The results are ORed together and registered to form the single request output. Software reaches the block through a word-addressed register bus with a combinational read path. Status and enable bits can be changed atomically through separate write-only set and clear registers, so no read-modify-write is needed.

Top module: `event_router`

## Requirements
- R1: After reset the polarity, mode, status and enable registers all read zero and `irqOut` is low.
- R2: With mode bit 0, a line is detected while its level equals the polarity bit (0 = low, 1 = high). The detection repeats on every cycle the level persists, so a status clear does not stick while that level is present.
- R3: With mode bit 1, the current sample is compared with the sample from the previous cycle. Polarity 0 reports a 1-to-0 change and polarity 1 reports a 0-to-1 change. A line that stays stable reports nothing.
- R4: Byte offsets, with the low two address bits ignored: polarity 0x000, mode 0x004, enable-clear 0xFD8, enable-set 0xFDC, status 0xFE0, enable 0xFE4, status-clear 0xFE8, status-set 0xFEC. Bit i of each register belongs to line i. Status is read-only, so writes to it have no effect. Reads of write-only or unmapped offsets return zero.
- R5: Writing 1 to a bit of the status-set or status-clear register sets or clears that status bit. Writing 0 leaves the bit unchanged.
- R6: Writing 1 to a bit of the enable-set or enable-clear register sets or clears that enable bit. Writing 0 leaves the bit unchanged.
- R7: When a detection and a status-clear write hit the same bit in the same cycle, the bit stays set.
- R8: A status bit set by a detection stays set until software clears it, even after the input returns to its idle value.
- R9: `irqOut` is the OR over all lines of status AND enable, delayed by one register stage.
- R10: A write that changes a line's polarity or mode bit restarts that line's edge detector. An edge whose new sample arrives on the first cycle under the new configuration is not reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (12) | Byte address of the register |
| busWdata | input | DATA_W (32) | Write data |
| busRdata | output | DATA_W (32) | Read data, valid in the same cycle as the read |
| evIn | input | NUM_EV (6) | Synchronised event lines |
| irqOut | output | 1 | Combined, registered request |

## Verification
A line sampled before clock edge k shows in the status register read after edge k, and in `irqOut` one edge later, after edge k+1. A register write takes effect at the edge that ends the access, and reads return data combinationally within the access cycle. The bench drives inputs and samples outputs on falling edges, and it reads status one falling edge after the stimulus and the request one edge after that. A sweep covers every line, all four detection settings and every pair of previous and current input values. The expected bit is computed arithmetically, and the bench allows for the fact that a level held while status is cleared wins that clear.

// File: rtl/evr_pkg.sv
package evr_pkg;
  localparam logic [11:0] OFF_POL    = 12'h000;
  localparam logic [11:0] OFF_MODE   = 12'h004;
  localparam logic [11:0] OFF_EN_CLR = 12'hFD8;
  localparam logic [11:0] OFF_EN_SET = 12'hFDC;
  localparam logic [11:0] OFF_STAT   = 12'hFE0;
  localparam logic [11:0] OFF_EN     = 12'hFE4;
  localparam logic [11:0] OFF_ST_CLR = 12'hFE8;
  localparam logic [11:0] OFF_ST_SET = 12'hFEC;

  typedef enum logic [2:0] {
    RD_NONE, RD_POL, RD_MODE, RD_STAT, RD_EN
  } rdSel_e;

  typedef struct packed {
    logic   wrPol;
    logic   wrMode;
    logic   enClr;
    logic   enSet;
    logic   stClr;
    logic   stSet;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/evr_ctrl.sv
module evr_ctrl
  import evr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb
);
  logic [ADDR_W-1:0] wordAddr;
  logic              doWr;
  logic              doRd;

  assign wordAddr = {busAddr[ADDR_W-1:2], 2'b00};
  assign doWr     = busSel && busWrite;
  assign doRd     = busSel && !busWrite;

  always_comb begin
    strb        = '0;
    strb.rdSel  = RD_NONE;
    strb.wrPol  = doWr && (wordAddr == ADDR_W'(OFF_POL));
    strb.wrMode = doWr && (wordAddr == ADDR_W'(OFF_MODE));
    strb.enClr  = doWr && (wordAddr == ADDR_W'(OFF_EN_CLR));
    strb.enSet  = doWr && (wordAddr == ADDR_W'(OFF_EN_SET));
    strb.stClr  = doWr && (wordAddr == ADDR_W'(OFF_ST_CLR));
    strb.stSet  = doWr && (wordAddr == ADDR_W'(OFF_ST_SET));
    if (doRd) begin
      if (wordAddr == ADDR_W'(OFF_POL))       strb.rdSel = RD_POL;
      else if (wordAddr == ADDR_W'(OFF_MODE)) strb.rdSel = RD_MODE;
      else if (wordAddr == ADDR_W'(OFF_STAT)) strb.rdSel = RD_STAT;
      else if (wordAddr == ADDR_W'(OFF_EN))   strb.rdSel = RD_EN;
    end
  end

  // R4: at most one write strobe per access
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrPol, strb.wrMode, strb.enClr, strb.enSet, strb.stClr, strb.stSet}));

  // R4: status is read-only, a write there raises no strobe
  a_r4_status_ro: assert property (@(posedge clk) disable iff (!rstN)
    (doWr && wordAddr == ADDR_W'(OFF_STAT)) |->
      !(strb.wrPol || strb.wrMode || strb.enClr || strb.enSet || strb.stClr || strb.stSet));
endmodule

// File: rtl/evr_datapath.sv
module evr_datapath
  import evr_pkg::*;
#(
  parameter int NUM_EV = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [NUM_EV-1:0] wrMask,
  input  logic [NUM_EV-1:0] evIn,
  output logic [DATA_W-1:0] rdata,
  output logic              irqOut
);
  logic [NUM_EV-1:0] polReg;
  logic [NUM_EV-1:0] modeReg;
  logic [NUM_EV-1:0] prevIn;
  logic [NUM_EV-1:0] primed;
  logic [NUM_EV-1:0] status;
  logic [NUM_EV-1:0] enable;
  logic [NUM_EV-1:0] hit;
  logic [NUM_EV-1:0] cfgChange;

  // per-line detector
  for (genvar i = 0; i < NUM_EV; i++) begin : g_det
    logic edgeHit;
    assign edgeHit = primed[i] & (polReg[i] ? (evIn[i] & ~prevIn[i])
                                            : (~evIn[i] & prevIn[i]));
    assign hit[i]  = modeReg[i] ? edgeHit : (evIn[i] == polReg[i]);
  end

  assign cfgChange = (strb.wrPol  ? (wrMask ^ polReg)  : '0)
                   | (strb.wrMode ? (wrMask ^ modeReg) : '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      polReg  <= '0;
      modeReg <= '0;
      prevIn  <= '0;
      primed  <= '0;
      status  <= '0;
      enable  <= '0;
      irqOut  <= 1'b0;
    end else begin
      if (strb.wrPol)  polReg  <= wrMask;
      if (strb.wrMode) modeReg <= wrMask;
      prevIn <= evIn;
      primed <= ~cfgChange;
      status <= (status & ~(strb.stClr ? wrMask : '0))
              | (strb.stSet ? wrMask : '0)
              | hit;
      enable <= (enable & ~(strb.enClr ? wrMask : '0))
              | (strb.enSet ? wrMask : '0);
      irqOut <= |(status & enable);
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_POL:  rdata = DATA_W'(polReg);
      RD_MODE: rdata = DATA_W'(modeReg);
      RD_STAT: rdata = DATA_W'(status);
      RD_EN:   rdata = DATA_W'(enable);
      default: rdata = '0;
    endcase
  end

  // R5: set bits appear in status
  a_r5_set_takes: assert property (@(posedge clk) disable iff (!rstN)
    strb.stSet |=> ((status & $past(wrMask)) == $past(wrMask)));

  // R6: enable clear and set act on the written ones
  a_r6_en_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.enClr |=> ((enable & $past(wrMask)) == '0));
  a_r6_en_set: assert property (@(posedge clk) disable iff (!rstN)
    strb.enSet |=> ((enable & $past(wrMask)) == $past(wrMask)));

  // R7: a detection survives a simultaneous clear
  a_r7_detect_wins: assert property (@(posedge clk) disable iff (!rstN)
    strb.stClr |=> ((status & $past(hit)) == $past(hit)));

  // R8: without a clear, status bits never drop
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !strb.stClr |=> ((status & $past(status)) == $past(status)));

  // R9: request follows status and enable one cycle later
  a_r9_irq_low: assert property (@(posedge clk) disable iff (!rstN)
    ((status & enable) == '0) |=> !irqOut);
  a_r9_irq_high: assert property (@(posedge clk) disable iff (!rstN)
    (|(status & enable)) |=> irqOut);
endmodule

// File: rtl/event_router.sv
module event_router
  import evr_pkg::*;
#(
  parameter int NUM_EV = 6,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [NUM_EV-1:0] evIn,
  output logic              irqOut
);
  strobe_t strb;
  logic    unusedBits;

  assign unusedBits = ^{busWdata[DATA_W-1:NUM_EV], busAddr[1:0]};

  evr_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb)
  );

  evr_datapath #(.NUM_EV(NUM_EV), .DATA_W(DATA_W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrMask (busWdata[NUM_EV-1:0]),
    .evIn   (evIn),
    .rdata  (busRdata),
    .irqOut (irqOut)
  );
endmodule

// File: tb/event_router_test.sv
`timescale 1ns/1ps
module event_router_test;
  localparam int N = 6;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [N-1:0] evIn = '1;
  logic        irqOut;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  event_router uut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    tick(3);
    // R1: reset values (inputs held high so level-low mode finds nothing)
    rd(12'h000, r); chk("R1 pol", r, 0);
    rd(12'h004, r); chk("R1 mode", r, 0);
    rd(12'hFE0, r); chk("R1 status", r, 0);
    rd(12'hFE4, r); chk("R1 enable", r, 0);
    chk("R1 irq", {31'd0, irqOut}, 0);
    rstN = 1'b1;
    tick(1);
    wr(12'hFDC, 32'h3F);

    // R2 R3 R9: sweep line, mode, polarity, previous and current sample
    for (int i = 0; i < N; i++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        for (int tr = 0; tr < 4; tr++) begin
          logic pol, md, pv, cu, e;
          pol = cfg[0]; md = cfg[1]; pv = tr[1]; cu = tr[0];
          wr(12'h000, 32'(pol) << i);
          wr(12'h004, (32'h3F & ~(32'd1 << i)) | (32'(md) << i));
          evIn = '0; evIn[i] = pv;
          tick(3);
          wr(12'hFE8, 32'h3F);
          evIn[i] = cu;
          tick(1);
          if (md) e = pol ? (cu & ~pv) : (pv & ~cu);
          else    e = (pv == pol) | (cu == pol);
          rd(12'hFE0, r);
          chk(md ? "R3 edge status" : "R2 level status", r, 32'(e) << i);
          tick(1);
          chk("R9 irq after detect", {31'd0, irqOut}, {31'd0, e});
        end
      end
    end

    // quiet setup: all falling-edge, inputs low and stable
    wr(12'h000, 0); wr(12'h004, 32'h3F); evIn = '0; tick(3);
    wr(12'hFE8, 32'h3F); wr(12'hFD8, 32'h3F);

    // R7: high-level line 0 survives a clear, then clears once gone
    wr(12'h000, 32'h01); wr(12'h004, 32'h3E); evIn[0] = 1'b1; tick(2);
    wr(12'hFE8, 32'h01);
    rd(12'hFE0, r); chk("R7 detect beats clear", r, 32'h01);
    evIn[0] = 1'b0;
    wr(12'hFE8, 32'h01);
    rd(12'hFE0, r); chk("R2 clear sticks once level gone", r, 32'h00);
    wr(12'h000, 0); wr(12'h004, 32'h3F); tick(3); wr(12'hFE8, 32'h3F);

    // R8: falling edge on line 3 stays latched
    evIn[3] = 1'b1; tick(3); wr(12'hFE8, 32'h3F);
    evIn[3] = 1'b0; tick(1);
    evIn[3] = 1'b1; tick(5);
    rd(12'hFE0, r); chk("R8 sticky after input returns", r, 32'h08);
    wr(12'hFE8, 32'h08);
    rd(12'hFE0, r); chk("R5 clear", r, 32'h00);
    evIn[3] = 1'b0; tick(2); wr(12'hFE8, 32'h3F);

    // R10: rising edge right after a polarity change is not reported
    wr(12'h000, 32'h04);
    evIn[2] = 1'b1; tick(1);
    rd(12'hFE0, r); chk("R10 edge masked after config", r, 32'h00);
    evIn[2] = 1'b0; tick(1);
    evIn[2] = 1'b1; tick(1);
    rd(12'hFE0, r); chk("R10 later edge seen", r, 32'h04);
    wr(12'h000, 0); evIn[2] = 1'b0; tick(2); wr(12'hFE8, 32'h3F);

    // R5: set register, zeros have no effect
    wr(12'hFEC, 32'h24);
    rd(12'hFE0, r); chk("R5 set", r, 32'h24);
    wr(12'hFEC, 32'h00);
    rd(12'hFE0, r); chk("R5 zero set no effect", r, 32'h24);
    wr(12'hFE8, 32'h00);
    rd(12'hFE0, r); chk("R5 zero clear no effect", r, 32'h24);
    wr(12'hFE8, 32'h04);
    rd(12'hFE0, r); chk("R5 partial clear", r, 32'h20);

    // R6 and R9: enable set and clear, request gating
    wr(12'hFDC, 32'h0A);
    rd(12'hFE4, r); chk("R6 enable set", r, 32'h0A);
    wr(12'hFDC, 32'h01);
    rd(12'hFE4, r); chk("R6 enable accumulate", r, 32'h0B);
    wr(12'hFD8, 32'h02);
    rd(12'hFE4, r); chk("R6 enable clear", r, 32'h09);
    tick(1);
    chk("R9 masked request low", {31'd0, irqOut}, 0);
    wr(12'hFDC, 32'h20);
    chk("R9 not yet high", {31'd0, irqOut}, 0);
    tick(1);
    chk("R9 high one cycle later", {31'd0, irqOut}, 1);

    // R4: map, write-only reads, read-only status
    rd(12'hFD8, r); chk("R4 enclr reads 0", r, 0);
    rd(12'hFDC, r); chk("R4 enset reads 0", r, 0);
    rd(12'hFE8, r); chk("R4 stclr reads 0", r, 0);
    rd(12'hFEC, r); chk("R4 stset reads 0", r, 0);
    rd(12'h100, r); chk("R4 unmapped reads 0", r, 0);
    wr(12'hFE0, 32'h3F);
    rd(12'hFE0, r); chk("R4 status read-only", r, 32'h20);
    wr(12'h000, 32'h15);
    rd(12'h000, r); chk("R4 pol readback", r, 32'h15);
    rd(12'h004, r); chk("R4 mode readback", r, 32'h3F);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule